// File: doc/BRIEF.md
# Pipelined Signed Fractional Divider

This block divides one signed 16-bit value by another using only shifts, additions and subtractions. A dividend/divisor pair can be presented on every clock. It supports two number formats. In fractional mode both operands are Q15 values in [-1, 1), and the quotient is a Q15 value truncated toward zero. In integer mode the operands are plain two's-complement integers, and the quotient is their truncated integer ratio. Both modes also return a 16-bit signed remainder.

The division recursion uses quotient digits of minus one and plus one. It is unrolled into one pipeline stage per quotient bit, and it never stops early when a partial remainder reaches zero. Two more stages follow the recursion:
- The first converts the digits to two's complement and corrects the overshoot past a zero partial remainder.
- The second makes the remainder carry the dividend's sign.

The result comes out a fixed number of cycles after its operands. A zero divisor raises one flag. A quotient that cannot be represented raises another; such results are only flagged and are not saturated.

Top module: `q15_nr_divider`

## Requirements
- R1: `out_valid` is high exactly 18 clock cycles after the cycle in which `in_valid` was high. Pairs may arrive in consecutive cycles, and each one yields its own result in order.
- R2: With `in_mode`=1 (fractional) and no flag raised, `out_quotient` equals (dividend·2^15)/divisor truncated toward zero.
- R3: With `in_mode`=1 and no flag raised, `out_remainder` equals dividend·2^15 − quotient·divisor. It is zero or has the dividend's sign, and its magnitude is below the divisor's.
- R4: With `in_mode`=0 (integer) and no flag raised, `out_quotient` equals dividend/divisor truncated toward zero, and `out_remainder` equals dividend − quotient·divisor.
- R5: Exact divisions, where the true remainder is zero, return the exact quotient and a remainder of 0 in both modes. This includes cases where the recursion passes through a zero partial remainder.
- R6: A zero divisor sets `out_div_by_zero`. The quotient is then 16'hFFFF and the remainder equals the dividend.
- R7: `out_overflow` is set in fractional mode when |divisor| ≤ |dividend|, including a zero divisor. It is set in integer mode only for dividend −32768 with divisor −1. It is clear in every other case.
- R8: After reset, and in every cycle in which `out_valid` is low, `out_valid`, `out_div_by_zero` and `out_overflow` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair present this cycle |
| in_mode | input | 1 | 1 = Q15 fractional, 0 = integer |
| in_dividend | input | 16 | Signed dividend |
| in_divisor | input | 16 | Signed divisor |
| out_valid | output | 1 | Result present this cycle |
| out_quotient | output | 16 | Signed quotient, truncated toward zero |
| out_remainder | output | 16 | Signed remainder, sign of the dividend |
| out_div_by_zero | output | 1 | Divisor was zero |
| out_overflow | output | 1 | Quotient not representable |

## Verification
The arithmetic assertions apply only to results with both flags low. They take for granted that those operands fall inside the representable range; the flags mark every operand pair outside it, so no assumption on the inputs is needed there. The reconstruction check assumes `in_mode`, `in_dividend` and `in_divisor` are stable only in cycles where `in_valid` is high, which is the only time the bench sets them. The bench covers both modes, with directed edge operands (−32768, ±1, zero, equal magnitudes, exact ratios) and fixed-seed random operands. It mixes flagged and unflagged cases and both back-to-back and gapped issue.

// File: rtl/q15div_pkg.sv
package q15div_pkg;
  typedef enum logic {
    MODE_INT = 1'b0,
    MODE_Q15 = 1'b1
  } div_mode_e;

  function automatic int unsigned pipe_depth(input int unsigned width);
    return width + 2;
  endfunction
endpackage

// File: rtl/q15div_step.sv
module q15div_step #(
  parameter int unsigned W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           vld_i,
  input  logic [2*W-1:0] pp_i,
  input  logic [W-1:0]   q_i,
  input  logic [W-1:0]   dvs_i,
  input  logic [W-1:0]   dnd_i,
  input  logic           dz_i,
  input  logic           ovf_i,
  output logic           vld_o,
  output logic [2*W-1:0] pp_o,
  output logic [W-1:0]   q_o,
  output logic [W-1:0]   dvs_o,
  output logic [W-1:0]   dnd_o,
  output logic           dz_o,
  output logic           ovf_o,
  output logic           digit_plus_o
);
  localparam int unsigned PW = 2 * W;

  // One non-restoring iteration: returns {digit, next partial remainder}.
  function automatic logic [PW:0] nr_iter(input logic [PW-1:0] pp, input logic [W-1:0] dvs);
    logic [PW-1:0] dd;
    logic [PW-1:0] sh;
    dd = {dvs, {W{1'b0}}};
    sh = {pp[PW-2:0], 1'b0};
    if (pp[PW-1] ^ dd[PW-1]) return {1'b0, sh + dd};
    else                     return {1'b1, sh - dd};
  endfunction

  logic [PW:0] step_res;
  assign step_res     = nr_iter(pp_i, dvs_i);
  assign digit_plus_o = step_res[PW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
      pp_o  <= '0;
      q_o   <= '0;
      dvs_o <= '0;
      dnd_o <= '0;
      dz_o  <= 1'b0;
      ovf_o <= 1'b0;
    end else begin
      vld_o <= vld_i;
      pp_o  <= step_res[PW-1:0];
      q_o   <= {q_i[W-2:0], step_res[PW]};
      dvs_o <= dvs_i;
      dnd_o <= dnd_i;
      dz_o  <= dz_i;
      ovf_o <= ovf_i;
    end
  end
endmodule

// File: rtl/q15div_fixup.sv
module q15div_fixup #(
  parameter int unsigned W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           vld_i,
  input  logic [2*W-1:0] pp_i,
  input  logic [W-1:0]   q_i,
  input  logic [W-1:0]   dvs_i,
  input  logic [W-1:0]   dnd_i,
  input  logic           dz_i,
  input  logic           ovf_i,
  output logic           vld_o,
  output logic [W-1:0]   q_o,
  output logic [W-1:0]   r_o,
  output logic [W-1:0]   dvs_o,
  output logic [W-1:0]   dnd_o,
  output logic           dz_o,
  output logic           ovf_o,
  output logic           zero_fix_o
);
  // Digit-set conversion plus correction of a run past a zero remainder.
  function automatic logic [2*W:0] conv_fix(input logic [W-1:0] q_raw, input logic [W-1:0] r_raw,
                                            input logic [W-1:0] dvs);
    logic [W-1:0] q;
    logic [W-1:0] r;
    logic         hit;
    q   = {q_raw[W-2:0], 1'b1};
    r   = r_raw;
    hit = 1'b0;
    if (r == dvs) begin
      q = q + 1'b1; r = '0; hit = 1'b1;
    end else if (r == W'(-dvs)) begin
      q = q - 1'b1; r = '0; hit = 1'b1;
    end
    return {hit, q, r};
  endfunction

  logic [2*W:0] fx;
  assign fx         = conv_fix(q_i, pp_i[2*W-1:W], dvs_i);
  assign zero_fix_o = fx[2*W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o <= 1'b0; q_o <= '0; r_o <= '0; dvs_o <= '0;
      dnd_o <= '0; dz_o <= 1'b0; ovf_o <= 1'b0;
    end else begin
      vld_o <= vld_i;
      q_o   <= fx[2*W-1:W];
      r_o   <= fx[W-1:0];
      dvs_o <= dvs_i;
      dnd_o <= dnd_i;
      dz_o  <= dz_i;
      ovf_o <= ovf_i;
    end
  end
endmodule

// File: rtl/q15div_signfix.sv
module q15div_signfix #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         vld_i,
  input  logic [W-1:0] q_i,
  input  logic [W-1:0] r_i,
  input  logic [W-1:0] dvs_i,
  input  logic [W-1:0] dnd_i,
  input  logic         dz_i,
  input  logic         ovf_i,
  output logic         vld_o,
  output logic [W-1:0] q_o,
  output logic [W-1:0] r_o,
  output logic         dz_o,
  output logic         ovf_o,
  output logic         sign_fix_o
);
  // Truncation: a nonzero remainder must share the dividend's sign.
  function automatic logic [2*W:0] trunc_fix(input logic [W-1:0] q_in, input logic [W-1:0] r_in,
                                             input logic [W-1:0] dvs, input logic [W-1:0] dnd);
    logic [W-1:0] q;
    logic [W-1:0] r;
    logic         hit;
    q   = q_in;
    r   = r_in;
    hit = (r != '0) && (dnd[W-1] ^ r[W-1]);
    if (hit) begin
      if (q[W-1]) begin q = q + 1'b1; r = r - dvs; end
      else        begin q = q - 1'b1; r = r + dvs; end
    end
    return {hit, q, r};
  endfunction

  logic [2*W:0] tf;
  assign tf         = trunc_fix(q_i, r_i, dvs_i, dnd_i);
  assign sign_fix_o = tf[2*W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o <= 1'b0; q_o <= '0; r_o <= '0; dz_o <= 1'b0; ovf_o <= 1'b0;
    end else begin
      vld_o <= vld_i;
      q_o   <= dz_i ? '1    : tf[2*W-1:W];
      r_o   <= dz_i ? dnd_i : tf[W-1:0];
      dz_o  <= dz_i & vld_i;
      ovf_o <= ovf_i & vld_i;
    end
  end
endmodule

// File: rtl/q15_nr_divider.sv
module q15_nr_divider #(
  parameter int unsigned W    = 16,
  parameter int unsigned FRAC = W - 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         in_mode,
  input  logic [W-1:0] in_dividend,
  input  logic [W-1:0] in_divisor,
  output logic         out_valid,
  output logic [W-1:0] out_quotient,
  output logic [W-1:0] out_remainder,
  output logic         out_div_by_zero,
  output logic         out_overflow
);
  import q15div_pkg::*;
  localparam int unsigned PW = 2 * W;
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  function automatic logic [W:0] mag(input logic [W-1:0] x);
    logic [W:0] xe;
    xe = {x[W-1], x};
    return x[W-1] ? (~xe + 1'b1) : xe;
  endfunction

  function automatic logic [PW-1:0] init_pp(input logic [W-1:0] n, input div_mode_e m);
    logic [PW-1:0] ne;
    ne = {{W{n[W-1]}}, n};
    return (m == MODE_Q15) ? (ne << FRAC) : ne;
  endfunction

  div_mode_e mode_in;
  assign mode_in = div_mode_e'(in_mode);

  logic           vld_s [0:W];
  logic [PW-1:0]  pp_s  [0:W];
  logic [W-1:0]   q_s   [0:W];
  logic [W-1:0]   dvs_s [0:W];
  logic [W-1:0]   dnd_s [0:W];
  logic           dz_s  [0:W];
  logic           ovf_s [0:W];
  logic [W-1:0]   digit_plus;

  assign vld_s[0] = in_valid;
  assign pp_s[0]  = init_pp(in_dividend, mode_in);
  assign q_s[0]   = '0;
  assign dvs_s[0] = in_divisor;
  assign dnd_s[0] = in_dividend;
  assign dz_s[0]  = (in_divisor == '0);
  assign ovf_s[0] = (mode_in == MODE_Q15) ? (mag(in_divisor) <= mag(in_dividend))
                                           : ((in_dividend == MOST_NEG) && (in_divisor == '1));

  for (genvar g = 0; g < W; g++) begin : g_iter
    q15div_step #(.W(W)) u_step (
      .clk(clk), .rst_n(rst_n),
      .vld_i(vld_s[g]), .pp_i(pp_s[g]), .q_i(q_s[g]), .dvs_i(dvs_s[g]),
      .dnd_i(dnd_s[g]), .dz_i(dz_s[g]), .ovf_i(ovf_s[g]),
      .vld_o(vld_s[g+1]), .pp_o(pp_s[g+1]), .q_o(q_s[g+1]), .dvs_o(dvs_s[g+1]),
      .dnd_o(dnd_s[g+1]), .dz_o(dz_s[g+1]), .ovf_o(ovf_s[g+1]),
      .digit_plus_o(digit_plus[g])
    );
  end

  logic         fx_vld, fx_dz, fx_ovf, zero_fix, sign_fix;
  logic [W-1:0] fx_q, fx_r, fx_dvs, fx_dnd;

  q15div_fixup #(.W(W)) u_fixup (
    .clk(clk), .rst_n(rst_n),
    .vld_i(vld_s[W]), .pp_i(pp_s[W]), .q_i(q_s[W]), .dvs_i(dvs_s[W]),
    .dnd_i(dnd_s[W]), .dz_i(dz_s[W]), .ovf_i(ovf_s[W]),
    .vld_o(fx_vld), .q_o(fx_q), .r_o(fx_r), .dvs_o(fx_dvs), .dnd_o(fx_dnd),
    .dz_o(fx_dz), .ovf_o(fx_ovf), .zero_fix_o(zero_fix)
  );

  q15div_signfix #(.W(W)) u_signfix (
    .clk(clk), .rst_n(rst_n),
    .vld_i(fx_vld), .q_i(fx_q), .r_i(fx_r), .dvs_i(fx_dvs), .dnd_i(fx_dnd),
    .dz_i(fx_dz), .ovf_i(fx_ovf),
    .vld_o(out_valid), .q_o(out_quotient), .r_o(out_remainder),
    .dz_o(out_div_by_zero), .ovf_o(out_overflow), .sign_fix_o(sign_fix)
  );
endmodule

// File: rtl/q15_nr_divider_chk.sv
module q15_nr_divider_chk #(
  parameter int unsigned W    = 16,
  parameter int unsigned FRAC = W - 1
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_mode,
  input logic [W-1:0] in_dividend,
  input logic [W-1:0] in_divisor,
  input logic         out_valid,
  input logic [W-1:0] out_quotient,
  input logic [W-1:0] out_remainder,
  input logic         out_div_by_zero,
  input logic         out_overflow
);
  localparam int unsigned LAT = q15div_pkg::pipe_depth(W);
  localparam int unsigned XW  = 2 * W + 2;

  logic         vld_p  [LAT];
  logic         mode_p [LAT];
  logic [W-1:0] dnd_p  [LAT];
  logic [W-1:0] dvs_p  [LAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LAT; i++) begin
        vld_p[i] <= 1'b0; mode_p[i] <= 1'b0; dnd_p[i] <= '0; dvs_p[i] <= '0;
      end
    end else begin
      vld_p[0] <= in_valid; mode_p[0] <= in_mode;
      dnd_p[0] <= in_dividend; dvs_p[0] <= in_divisor;
      for (int i = 1; i < LAT; i++) begin
        vld_p[i] <= vld_p[i-1]; mode_p[i] <= mode_p[i-1];
        dnd_p[i] <= dnd_p[i-1]; dvs_p[i] <= dvs_p[i-1];
      end
    end
  end

  function automatic logic [XW-1:0] sx(input logic [W-1:0] v);
    return {{(XW-W){v[W-1]}}, v};
  endfunction

  function automatic logic [W:0] absv(input logic [W-1:0] v);
    return v[W-1] ? (~{1'b1, v} + 1'b1) : {1'b0, v};
  endfunction

  logic [W-1:0]  n_o, d_o;
  logic          m_o, clean;
  logic [XW-1:0] recon, target;
  assign n_o    = dnd_p[LAT-1];
  assign d_o    = dvs_p[LAT-1];
  assign m_o    = mode_p[LAT-1];
  assign clean  = out_valid && !out_div_by_zero && !out_overflow;
  assign recon  = sx(out_quotient) * sx(d_o) + sx(out_remainder);
  assign target = m_o ? (sx(n_o) << FRAC) : sx(n_o);

  a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == vld_p[LAT-1]);
  // R2 fractional and R4 integer: quotient and remainder rebuild the scaled dividend
  a_r2_recon: assert property (@(posedge clk) disable iff (!rst_n)
    clean |-> recon == target);
  a_r3_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
    clean |-> absv(out_remainder) < absv(d_o));
  a_r3_rem_sign: assert property (@(posedge clk) disable iff (!rst_n)
    clean |-> (out_remainder == '0) || (out_remainder[W-1] == n_o[W-1]));
  a_r6_dz_flag: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_div_by_zero == (d_o == '0));
  a_r6_dz_result: assert property (@(posedge clk) disable iff (!rst_n)
    out_div_by_zero |-> (out_quotient == '1) && (out_remainder == n_o));
  a_r7_q15_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && m_o) |-> out_overflow == (absv(d_o) <= absv(n_o)));
  a_r8_flags_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !out_div_by_zero && !out_overflow);
endmodule

bind q15_nr_divider q15_nr_divider_chk #(.W(W), .FRAC(FRAC)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
  .in_dividend(in_dividend), .in_divisor(in_divisor), .out_valid(out_valid),
  .out_quotient(out_quotient), .out_remainder(out_remainder),
  .out_div_by_zero(out_div_by_zero), .out_overflow(out_overflow)
);

// File: tb/q15_nr_divider_bench.sv
module q15_nr_divider_bench;
  localparam int LAT = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_mode = 1'b0;
  logic [15:0] in_dividend = '0, in_divisor = '0;
  logic out_valid, out_div_by_zero, out_overflow;
  logic [15:0] out_quotient, out_remainder;

  always #2 clk = ~clk;

  q15_nr_divider u_q15_nr_divider (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
    .in_dividend(in_dividend), .in_divisor(in_divisor), .out_valid(out_valid),
    .out_quotient(out_quotient), .out_remainder(out_remainder),
    .out_div_by_zero(out_div_by_zero), .out_overflow(out_overflow)
  );

  typedef struct {
    logic [15:0] q;
    logic [15:0] r;
    logic        dz;
    logic        ovf;
    int          due;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  bit   finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic longint mag(input logic signed [15:0] v);
    return (v < 0) ? -longint'(v) : longint'(v);
  endfunction

  task automatic send(input logic signed [15:0] n, input logic signed [15:0] d,
                      input logic m, input string tag);
    exp_t   e;
    longint num, qq, rr;
    @(negedge clk);
    in_valid = 1'b1; in_mode = m; in_dividend = n; in_divisor = d;
    num   = m ? longint'(n) * 32768 : longint'(n);
    e.dz  = (d == 0);
    e.ovf = m ? (mag(d) <= mag(n)) : (n == -16'sd32768 && d == -16'sd1);
    if (e.dz) begin
      e.q = 16'hFFFF; e.r = n;
    end else if (!e.ovf) begin
      qq = num / longint'(d); rr = num % longint'(d);
      e.q = qq[15:0]; e.r = rr[15:0];
    end else begin
      e.q = '0; e.r = '0;
    end
    e.due = cyc + LAT;
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_dividend = 16'hDEAD; in_divisor = 16'h0000; in_mode = 1'b1;
    end
  endtask

  // Monitor: pops one expected item per result.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (out_valid) begin
        if (sb.size() == 0) begin
          check(1'b0, "R1", "unexpected result", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(cyc == e.due, "R1", "latency cycle", cyc, e.due);
          check(out_div_by_zero == e.dz, "R6", "div_by_zero flag", out_div_by_zero, e.dz);
          check(out_overflow == e.ovf, "R7", "overflow flag", out_overflow, e.ovf);
          if (e.dz || !e.ovf) begin
            check(out_quotient == e.q, e.tag, "quotient", out_quotient, e.q);
            check(out_remainder == e.r, e.tag, "remainder", out_remainder, e.r);
          end
        end
      end else begin
        check(!out_div_by_zero && !out_overflow, "R8", "flags while idle",
              {out_div_by_zero, out_overflow}, 0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic signed [15:0] a, b;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R8", "out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && !out_div_by_zero && !out_overflow, "R8", "state after reset",
          {out_valid, out_div_by_zero, out_overflow}, 0);

    // Fractional directed cases (R2/R3), exact ones (R5)
    send(16'sd16384, 16'sd32767, 1'b1, "R2/R3");
    send(16'sd16384, -16'sd32768, 1'b1, "R5");
    send(-16'sd1, -16'sd32768, 1'b1, "R5");
    send(16'sd1, 16'sd3, 1'b1, "R2/R3");
    send(-16'sd1000, 16'sd3001, 1'b1, "R2/R3");
    send(16'sd8192, -16'sd16384, 1'b1, "R5");
    send(16'sd0, -16'sd5, 1'b1, "R5");
    send(16'sd100, 16'sd100, 1'b1, "R7");
    send(-16'sd32768, 16'sd32767, 1'b1, "R7");
    send(16'sd7, 16'sd0, 1'b1, "R6");
    idle(3);
    // Integer directed cases (R4), exact ones (R5)
    send(16'sd100, 16'sd10, 1'b0, "R5");
    send(-16'sd100, 16'sd10, 1'b0, "R5");
    send(16'sd7, -16'sd2, 1'b0, "R4");
    send(-16'sd7, 16'sd2, 1'b0, "R4");
    send(-16'sd32768, 16'sd1, 1'b0, "R5");
    send(-16'sd32768, -16'sd2, 1'b0, "R5");
    send(16'sd32767, -16'sd32768, 1'b0, "R4");
    send(-16'sd32768, -16'sd1, 1'b0, "R7");
    send(-16'sd123, 16'sd0, 1'b0, "R6");
    send(16'sd0, 16'sd0, 1'b0, "R6");
    idle(1);
    // Random back-to-back and gapped traffic in both modes (R1 throughput)
    for (int i = 0; i < 600; i++) begin
      a = $signed(16'($urandom()));
      b = $signed(16'($urandom()));
      if ((i % 5) == 0) b = $signed(16'($urandom() % 9)) - 16'sd4;
      if ((i % 2) == 0) send(a, b, 1'b1, "R2/R3");
      else              send(a, b, 1'b0, "R4");
      if ((i % 37) == 0) idle(2);
    end
    idle(LAT + 4);
    check(sb.size() == 0, "R1", "results outstanding", sb.size(), 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule